// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a wedged I2C bus. A target that was interrupted mid-byte can keep SDA low forever, and no controller can then issue a START. The sequencer takes both bus pins over as open-drain outputs. It releases SDA and clocks SCL until the target lets SDA go. It then issues a START immediately followed by a STOP, which returns every target's state machine to idle. While it runs, `busy` holds the normal I2C controller off the pins. When it ends, it pulses `done` and leaves a result code that stays readable until the next run.

An output enable of 1 pulls the line low, and 0 releases it. Every decision uses the sensed pin level after a two-flop synchroniser, never the level that was written. All waits are one time unit long. The unit is `TICK_CYCLES` clocks, and by default it is derived from `CLK_HZ` and `UNIT_US`, which gives 10 µs. Before each recovery clock the block waits for SCL to read high, so a target that stretches the clock is respected. Both loops are bounded: at most `MAX_PULSES`+1 clocks and at most `MAX_RETRIES`+1 stretch waits.

States are ST_IDLE, ST_SDA_CHK, ST_SCL_CHK, ST_STRETCH, ST_CLK_LO, ST_CLK_HI, ST_START_A, ST_START_B, ST_STOP_A and ST_STOP_B. The transitions are:
- ST_IDLE to ST_SDA_CHK, on a request.
- ST_SDA_CHK to ST_START_A, when SDA reads high.
- ST_SDA_CHK to ST_IDLE, with SDA-stuck, when SDA reads low and the pulse limit is passed.
- ST_SDA_CHK to ST_SCL_CHK, when SDA reads low and the limit is not passed.
- ST_SCL_CHK to ST_CLK_LO, when SCL reads high.
- ST_SCL_CHK to ST_IDLE, with SCL-stuck, when SCL reads low and the retry limit is passed.
- ST_SCL_CHK to ST_STRETCH, when SCL reads low and the limit is not passed.
- ST_STRETCH to ST_SCL_CHK, when the unit expires.
- ST_CLK_LO to ST_CLK_HI to ST_SDA_CHK, one unit each.
- ST_START_A to ST_START_B to ST_STOP_A to ST_STOP_B, one unit each, then ST_IDLE with OK.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, both output enables are 0, `busy` and `done` are 0, and `result` is 2'b00 (none).
- R2: A `recover_req` pulse in idle raises `busy` at the next clock edge and clears `result` to 2'b00. A request while `busy` is high has no effect on the run.
- R3: Whenever `busy` is low, both output enables are 0, so both lines are released.
- R4: If SDA reads high at entry, no SCL pulse is issued, and `busy` stays high for exactly 1+4T cycles (T = `TICK_CYCLES`).
- R5: Each recovery clock holds `scl_oe` at 1 for exactly T cycles and then releases it for T cycles, with `sda_oe` at 0. Clocks repeat while synchronised SDA reads low.
- R6: If the target releases SDA after N recovery clocks, with N ≤ `MAX_PULSES`+1, the run issues exactly N clocks and ends with `result` = 2'b01 (OK). `busy` lasts 1+4T+N(2T+2) cycles.
- R7: If SDA still reads low after `MAX_PULSES`+1 clocks, the run ends with `result` = 2'b10 (SDA stuck), issues no START, and `busy` lasts 1+(MAX_PULSES+1)(2T+2) cycles.
- R8: A recovery clock starts only after synchronised SCL reads high. SCL is resampled once every T+1 cycles. If it still reads low after `MAX_RETRIES`+1 waits, the run ends with `result` = 2'b11 (SCL stuck), and `busy` lasts 2+(MAX_RETRIES+1)(T+1) cycles when SCL is held low from the start.
- R9: The closing pair runs in this order: `sda_oe` rises while `scl_oe` is 0; T cycles later `scl_oe` rises for T cycles; SCL is released; `sda_oe` is released T cycles after that, so `sda_oe` is high for 3T cycles.
- R10: `done` is a one-cycle pulse in the cycle where `busy` has just fallen. `result` changes only at a request or at `done`, and it holds between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | One-cycle request to start recovery |
| scl_in | input | 1 | Sensed SCL pin level |
| sda_in | input | 1 | Sensed SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Recovery in progress; the main controller must stay off the pins |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 00 none, 01 OK, 10 SDA stuck, 11 SCL stuck |

## Verification
The hardest situations to reach are the two loop limits. One is a target that keeps SDA low past the last permitted clock; the other is a target that keeps SCL low across every stretch wait. The bench models the target as counting the sequencer's own SCL releases and letting SDA go after a chosen number, and sweeps that number from 0 up to two beyond the limit. A separate model holds SCL low for a programmed number of cycles, chosen either to end safely inside the retry window or to outlast it. Each expected busy duration is computed from the cycle formulas in the requirements, so a loop limit that is off by one changes the measured count.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SDA_CHK,
        ST_SCL_CHK,
        ST_STRETCH,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_START_A,
        ST_START_B,
        ST_STOP_A,
        ST_STOP_B
    } rec_state_e;

    typedef enum logic [1:0] {
        RES_NONE      = 2'b00,
        RES_OK        = 2'b01,
        RES_SDA_STUCK = 2'b10,
        RES_SCL_STUCK = 2'b11
    } rec_result_e;

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Idle bus level is high, so every stage resets to all ones
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/unstick_tick.sv
module unstick_tick #(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    generate
        if (TICK_CYCLES <= 1) begin : g_single
            assign expire = run;
        end else begin : g_count
            localparam int CW = $clog2(TICK_CYCLES + 1);
            localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
            logic [CW-1:0] cnt_q;

            assign expire = run && (cnt_q == LAST);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run || expire) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            // R5
            tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);
        end
    endgenerate

endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
    import unstick_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int UNIT_US     = 10,
    parameter int TICK_CYCLES = (CLK_HZ / 1_000_000) * UNIT_US,
    parameter int MAX_PULSES  = 10,
    parameter int MAX_RETRIES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       recover_req,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic [1:0] result
);
    localparam int PCW = $clog2(MAX_PULSES + 2);
    localparam int RCW = $clog2(MAX_RETRIES + 2);
    localparam logic [PCW-1:0] PULSE_LIM = PCW'(MAX_PULSES);
    localparam logic [RCW-1:0] RETRY_LIM = RCW'(MAX_RETRIES);

    rec_state_e     state_q, state_d;
    logic [PCW-1:0] pulse_q, pulse_d;
    logic [RCW-1:0] retry_q, retry_d;
    rec_result_e    result_q, result_d;
    logic           done_q, done_d;
    logic           scl_s, sda_s;
    logic           tick_run, tick_exp;

    unstick_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    unstick_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tick_run),
        .expire (tick_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pulse_q  <= '0;
            retry_q  <= '0;
            result_q <= RES_NONE;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            pulse_q  <= pulse_d;
            retry_q  <= retry_d;
            result_q <= result_d;
            done_q   <= done_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        pulse_d  = pulse_q;
        retry_d  = retry_q;
        result_d = result_q;
        done_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (recover_req) begin
                    state_d  = ST_SDA_CHK;
                    pulse_d  = '0;
                    result_d = RES_NONE;
                end
            end
            ST_SDA_CHK: begin
                if (sda_s) begin
                    state_d = ST_START_A;
                end else if (pulse_q > PULSE_LIM) begin
                    state_d  = ST_IDLE;
                    result_d = RES_SDA_STUCK;
                    done_d   = 1'b1;
                end else begin
                    pulse_d = pulse_q + 1'b1;
                    retry_d = '0;
                    state_d = ST_SCL_CHK;
                end
            end
            ST_SCL_CHK: begin
                if (scl_s) begin
                    state_d = ST_CLK_LO;
                end else if (retry_q > RETRY_LIM) begin
                    state_d  = ST_IDLE;
                    result_d = RES_SCL_STUCK;
                    done_d   = 1'b1;
                end else begin
                    retry_d = retry_q + 1'b1;
                    state_d = ST_STRETCH;
                end
            end
            ST_STRETCH: if (tick_exp) state_d = ST_SCL_CHK;
            ST_CLK_LO:  if (tick_exp) state_d = ST_CLK_HI;
            ST_CLK_HI:  if (tick_exp) state_d = ST_SDA_CHK;
            ST_START_A: if (tick_exp) state_d = ST_START_B;
            ST_START_B: if (tick_exp) state_d = ST_STOP_A;
            ST_STOP_A:  if (tick_exp) state_d = ST_STOP_B;
            ST_STOP_B: begin
                if (tick_exp) begin
                    state_d  = ST_IDLE;
                    result_d = RES_OK;
                    done_d   = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        scl_oe   = 1'b0;
        sda_oe   = 1'b0;
        tick_run = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SDA_CHK, ST_SCL_CHK: ;
            ST_STRETCH, ST_CLK_HI, ST_STOP_B: tick_run = 1'b1;
            ST_CLK_LO: begin
                scl_oe   = 1'b1;
                tick_run = 1'b1;
            end
            ST_START_A, ST_STOP_A: begin
                sda_oe   = 1'b1;
                tick_run = 1'b1;
            end
            ST_START_B: begin
                scl_oe   = 1'b1;
                sda_oe   = 1'b1;
                tick_run = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> (done || busy));

    // R8
    clk_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_oe) && !sda_oe) |-> $past(scl_s));

    // R9
    start_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (!scl_oe && $past(sda_s)));

    // R7
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q <= PULSE_LIM + 1'b1);

endmodule

// File: tb/i2c_unstick_tb_top.sv
module i2c_unstick_tb_top;
    localparam int T  = 4;
    localparam int MP = 10;
    localparam int MR = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    always #5 clk = ~clk;

    logic scl_oe, sda_oe, busy, done;
    logic [1:0] result;

    int n_chk = 0;
    int n_fail = 0;

    // Target model configuration
    int tgt_n = 0;
    int rel_base = 0;
    int hold_end = 0;

    // Cumulative monitor counters
    int cyc = 0, rel_cnt = 0, pulse_cnt = 0, sda_rise = 0;
    int busy_cyc = 0, done_cnt = 0, lo_bad = 0, seq_bad = 0;
    int scl_run = 0, sda_run = 0;
    logic p_scl = 1'b0, p_sda = 1'b0;

    wire sda_bus = !(sda_oe || ((rel_cnt - rel_base) < tgt_n));
    wire scl_bus = !(scl_oe || (cyc < hold_end));

    i2c_unstick #(
        .TICK_CYCLES (T),
        .MAX_PULSES  (MP),
        .MAX_RETRIES (MR)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .recover_req (req),
        .scl_in      (scl_bus),
        .sda_in      (sda_bus),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .busy        (busy),
        .done        (done),
        .result      (result)
    );

    always @(negedge clk) begin
        cyc   <= cyc + 1;
        p_scl <= scl_oe;
        p_sda <= sda_oe;
        if (busy) busy_cyc <= busy_cyc + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (scl_oe && !p_scl && !sda_oe) pulse_cnt <= pulse_cnt + 1;
        if (scl_oe && !p_scl && sda_oe && sda_run != T) seq_bad <= seq_bad + 1;
        if (!scl_oe && p_scl) begin
            rel_cnt <= rel_cnt + 1;
            if (scl_run != T) lo_bad <= lo_bad + 1;
        end
        if (sda_oe && !p_sda) begin
            sda_rise <= sda_rise + 1;
            if (scl_oe) seq_bad <= seq_bad + 1;
        end
        if (!sda_oe && p_sda && (scl_oe || p_scl || sda_run != 3*T)) seq_bad <= seq_bad + 1;
        scl_run <= scl_oe ? scl_run + 1 : 0;
        sda_run <= sda_oe ? sda_run + 1 : 0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // n: SCL releases before target lets SDA go; hold: cycles SCL held low
    task automatic run_case(input int n, input int hold, input int exp_res,
                            input int exp_pulses, input int exp_busy,
                            input bit poke, input string tag);
        int b_pulse, b_rise, b_busy, b_done, b_lo, b_seq;
        @(negedge clk);
        rel_base = rel_cnt;
        tgt_n    = n;
        hold_end = (hold == 0) ? 0 : cyc + 4 + hold;
        repeat (4) @(negedge clk);
        #1;
        b_pulse = pulse_cnt; b_rise = sda_rise; b_busy = busy_cyc;
        b_done = done_cnt; b_lo = lo_bad; b_seq = seq_bad;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        #1;
        chk(busy == 1'b1, {tag, " R2 busy after request"}, busy, 1);
        chk(result == 2'b00, {tag, " R2 result cleared"}, result, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        while (done_cnt == b_done) @(negedge clk);
        #1;
        chk(result == exp_res[1:0], {tag, " R6 R7 R8 result"}, result, exp_res);
        chk(pulse_cnt - b_pulse == exp_pulses, {tag, " R5 pulse count"}, pulse_cnt - b_pulse, exp_pulses);
        if (exp_busy >= 0)
            chk(busy_cyc - b_busy == exp_busy, {tag, " R4 R6 R7 R8 busy cycles"}, busy_cyc - b_busy, exp_busy);
        chk(sda_rise - b_rise == ((exp_res == 1) ? 1 : 0), {tag, " R9 start count"},
            sda_rise - b_rise, (exp_res == 1) ? 1 : 0);
        chk(lo_bad == b_lo, {tag, " R5 low width"}, lo_bad - b_lo, 0);
        chk(seq_bad == b_seq, {tag, " R9 start/stop order"}, seq_bad - b_seq, 0);
        repeat (5) @(negedge clk);
        #1;
        chk(done_cnt - b_done == 1, {tag, " R10 single done"}, done_cnt - b_done, 1);
        chk(result == exp_res[1:0], {tag, " R10 result held"}, result, exp_res);
        chk(!busy && !scl_oe && !sda_oe, {tag, " R3 lines released"}, {busy, scl_oe, sda_oe}, 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        #1;
        chk(scl_oe == 0 && sda_oe == 0, "R1 enables in reset", {scl_oe, sda_oe}, 0);
        chk(busy == 0, "R1 busy in reset", busy, 0);
        chk(done == 0, "R1 done in reset", done, 0);
        chk(result == 2'b00, "R1 result in reset", result, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // SDA stuck sweep: R4 (n=0), R6 (n<=MP+1), R7 (n>MP+1)
        for (int n = 0; n <= MP + 3; n++) begin
            if (n <= MP + 1)
                run_case(n, 0, 1, n, 1 + 4*T + n*(2*T + 2), 1'b0, $sformatf("R6 n=%0d", n));
            else
                run_case(n, 0, 2, MP + 1, 1 + (MP + 1)*(2*T + 2), 1'b0, $sformatf("R7 n=%0d", n));
        end
        // R2: request while busy is ignored
        run_case(3, 0, 1, 3, 1 + 4*T + 3*(2*T + 2), 1'b1, "R2 poke");
        // R8: stretch ends inside the retry window
        run_case(2, 9*(T + 1), 1, 2, -1, 1'b0, "R8 stretch ok");
        // R8: stretch outlasts every retry
        run_case(2, 20*(T + 1), 3, 0, 2 + (MR + 1)*(T + 1), 1'b0, "R8 stretch stuck");
        // R4: SDA high at entry, SCL held low makes no difference
        run_case(0, 40*(T + 1), 1, 0, 1 + 4*T, 1'b0, "R4 scl low sda high");
        @(negedge clk);
        hold_end = 0;
        repeat (4) @(negedge clk);
        run_case(1, 0, 1, 1, 1 + 4*T + (2*T + 2), 1'b0, "R6 after stretch");
    endtask

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule